// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. A shared free-running main counter is fed in together with a tick strobe that marks the cycles in which the counter has just advanced. On every tick the channel compares the counter with its programmed comparator. When they are equal, and both the channel and the global enables are on, it emits a one-cycle fire strobe to the interrupt routing logic. Bus decoding and interrupt delivery sit outside the block. The channel sees only decoded write strobes for its configuration register and for the two halves of its comparator.

The channel has a one-shot mode and a periodic mode. In periodic mode a hidden period register holds the last comparator value written. After each match the comparator steps forward by that amount. A set-value bit lets software place the live comparator directly while periodic mode is on. A 32-bit mode narrows the comparison, the comparator and the period to the low half of the 64-bit counter. In 32-bit one-shot mode the channel also fires when the low half of the counter rolls over to zero.

If a register write lands in the same cycle as a periodic reload, the write takes effect and the reload is dropped. At most one of the three write strobes is expected in any cycle. If several are raised together, the configuration write wins, then the low half, then the high half.

Top module: `etc_channel`

## Requirements
- R1: After reset the configuration readback is 0x30, the comparator reads all ones, the period reads zero and the fire strobe is low. Readback bit 4 is a constant 1 advertising periodic capability, and bit 5 is a constant 1 advertising 64-bit capability.
- R2: When a tick arrives with the counter equal to the comparator, and both the channel enable (configuration bit 0) and the global enable are set, fire is high for exactly the next cycle. Without such a tick, fire stays low.
- R3: With 32-bit mode off, all 64 bits take part in the comparison. In one-shot mode (configuration bit 1 clear) the comparator is left unchanged after it fires.
- R4: A configuration write with the 32-bit mode bit (bit 2) set clears the upper halves of both the comparator and the period. In 32-bit mode only the low halves are compared, and writes to the comparator high half have no effect.
- R5: In 32-bit one-shot mode, a tick on which the counter's low half is zero also fires. In 64-bit mode, or in periodic mode, such a tick does not fire unless the comparator matches.
- R6: A comparator half write loads that half of the live comparator when the channel is one-shot or when the set-value bit (bit 3) is set. In periodic mode the same write also loads that half of the period. Every comparator write clears the set-value bit.
- R7: In periodic mode with a nonzero period, a firing match makes the comparator equal to comparator plus period from the next cycle on. In 32-bit mode the sum is cut to 32 bits.
- R8: A period written in periodic mode has bit 31 cleared in 32-bit mode. A high-half period write in 64-bit mode clears bit 63.
- R9: A periodic match with a zero period still fires but leaves the comparator unchanged.
- R10: With the channel enable clear, or with the global enable low, no fire is produced, and ticks leave the comparator and the period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 64 | Shared main counter value |
| cnt_tick | input | 1 | Counter advanced this cycle; comparison is done only when it is high |
| glb_en | input | 1 | Global enable for the whole timer block |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration write data: bit0 enable, bit1 periodic, bit2 32-bit mode, bit3 set-value |
| cmp_lo_we | input | 1 | Comparator low-half write strobe |
| cmp_hi_we | input | 1 | Comparator high-half write strobe |
| cmp_wdata | input | 32 | Comparator half write data |
| cfg_rd | output | 6 | Configuration readback including the two capability bits |
| cmp_rd | output | 64 | Live comparator |
| period_rd | output | 64 | Hidden period register |
| fire | output | 1 | One-cycle event strobe |

## Verification
On every cycle the assertions check three things. Fire only follows an enabled tick. In 32-bit mode the upper halves of the comparator and period stay zero, and bit 63 of the period is never set. A disabled channel, or one with a zero period, leaves its comparator alone when no write arrives. The exact comparator arithmetic can only be shown by the bench's directed scenarios. These cover the reload step and its 32-bit truncation, the wrap event in 32-bit one-shot mode, and the set-value gating of comparator writes. They also cover truncation on a switch to 32-bit mode and the masking of period values.

// File: rtl/etc_pkg.sv
package etc_pkg;

  typedef struct packed {
    logic sz64_cap;
    logic per_cap;
    logic setval;
    logic mode32;
    logic periodic;
    logic chan_en;
  } etc_cfg_t;

  localparam int ETC_CFG_WR_W = 4;
  localparam int ETC_CFG_RD_W = $bits(etc_cfg_t);

endpackage

// File: rtl/etc_cfg_reg.sv
module etc_cfg_reg
  import etc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [ETC_CFG_WR_W-1:0] wdata,
  input  logic                    clr_setval,
  output etc_cfg_t                cfg
);

  logic [ETC_CFG_WR_W-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (we) begin
      bits_q <= wdata;
    end else if (clr_setval) begin
      bits_q[3] <= 1'b0;
    end
  end

  always_comb begin
    cfg          = '0;
    cfg.chan_en  = bits_q[0];
    cfg.periodic = bits_q[1];
    cfg.mode32   = bits_q[2];
    cfg.setval   = bits_q[3];
    cfg.per_cap  = 1'b1;
    cfg.sz64_cap = 1'b1;
  end

endmodule

// File: rtl/etc_match.sv
module etc_match
  import etc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             tick,
  input  logic             glb_en,
  input  etc_cfg_t         cfg,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] per,
  output logic             eq_hit,
  output logic             wrap_hit,
  output logic             evt,
  output logic             reload
);

  localparam int HALF = CNT_W / 2;

  function automatic logic width_equal(input logic [CNT_W-1:0] a,
                                       input logic [CNT_W-1:0] b,
                                       input logic narrow);
    if (narrow) return a[HALF-1:0] == b[HALF-1:0];
    return a == b;
  endfunction

  logic live;

  assign live     = tick && glb_en && cfg.chan_en;
  assign eq_hit   = width_equal(cnt, cmp, cfg.mode32);
  assign wrap_hit = cfg.mode32 && !cfg.periodic && (cnt[HALF-1:0] == '0);
  assign evt      = live && (eq_hit || wrap_hit);
  assign reload   = live && eq_hit && cfg.periodic && (per != '0);

endmodule

// File: rtl/etc_cmp_store.sv
module etc_cmp_store
  import etc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  etc_cfg_t          cfg,
  input  logic              cfg_we,
  input  logic              cfg_m32_new,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [CNT_W/2-1:0] wdata,
  input  logic              reload,
  output logic [CNT_W-1:0]  cmp_q,
  output logic [CNT_W-1:0]  per_q
);

  localparam int HALF = CNT_W / 2;

  function automatic logic [HALF-1:0] drop_msb(input logic [HALF-1:0] v);
    return {1'b0, v[HALF-2:0]};
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] p,
                                               input logic narrow);
    logic [CNT_W-1:0] s;
    s = c + p;
    if (narrow) s[CNT_W-1:HALF] = '0;
    return s;
  endfunction

  logic load_cmp;
  assign load_cmp = !cfg.periodic || cfg.setval;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      per_q <= '0;
    end else if (cfg_we) begin
      if (cfg_m32_new) begin
        cmp_q[CNT_W-1:HALF] <= '0;
        per_q[CNT_W-1:HALF] <= '0;
      end
    end else if (lo_we) begin
      if (load_cmp) cmp_q[HALF-1:0] <= wdata;
      if (cfg.periodic)
        per_q[HALF-1:0] <= cfg.mode32 ? drop_msb(wdata) : wdata;
    end else if (hi_we) begin
      if (!cfg.mode32) begin
        if (load_cmp) cmp_q[CNT_W-1:HALF] <= wdata;
        if (cfg.periodic) per_q[CNT_W-1:HALF] <= drop_msb(wdata);
      end
    end else if (reload) begin
      cmp_q <= advance(cmp_q, per_q, cfg.mode32);
    end
  end

endmodule

// File: rtl/etc_channel.sv
module etc_channel
  import etc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        cnt_val,
  input  logic                    cnt_tick,
  input  logic                    glb_en,
  input  logic                    cfg_we,
  input  logic [ETC_CFG_WR_W-1:0] cfg_wdata,
  input  logic                    cmp_lo_we,
  input  logic                    cmp_hi_we,
  input  logic [CNT_W/2-1:0]      cmp_wdata,
  output logic [ETC_CFG_RD_W-1:0] cfg_rd,
  output logic [CNT_W-1:0]        cmp_rd,
  output logic [CNT_W-1:0]        period_rd,
  output logic                    fire
);

  etc_cfg_t         cfg;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] per_q;
  logic             eq_hit;
  logic             wrap_hit;
  logic             evt;
  logic             reload;
  logic             fire_q;

  etc_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .wdata      (cfg_wdata),
    .clr_setval (cmp_lo_we || cmp_hi_we),
    .cfg        (cfg)
  );

  etc_match #(.CNT_W(CNT_W)) u_match (
    .cnt      (cnt_val),
    .tick     (cnt_tick),
    .glb_en   (glb_en),
    .cfg      (cfg),
    .cmp      (cmp_q),
    .per      (per_q),
    .eq_hit   (eq_hit),
    .wrap_hit (wrap_hit),
    .evt      (evt),
    .reload   (reload)
  );

  etc_cmp_store #(.CNT_W(CNT_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .cfg_we      (cfg_we),
    .cfg_m32_new (cfg_wdata[2]),
    .lo_we       (cmp_lo_we),
    .hi_we       (cmp_hi_we),
    .wdata       (cmp_wdata),
    .reload      (reload),
    .cmp_q       (cmp_q),
    .per_q       (per_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= evt;
  end

  assign cfg_rd    = cfg;
  assign cmp_rd    = cmp_q;
  assign period_rd = per_q;
  assign fire      = fire_q;

endmodule

// File: rtl/etc_channel_chk.sv
module etc_channel_chk
  import etc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cnt_tick,
  input logic                    glb_en,
  input logic                    cfg_we,
  input logic                    cmp_lo_we,
  input logic                    cmp_hi_we,
  input logic [ETC_CFG_RD_W-1:0] cfg_rd,
  input logic [CNT_W-1:0]        cmp_rd,
  input logic [CNT_W-1:0]        period_rd,
  input logic                    fire
);

  localparam int HALF = CNT_W / 2;

  logic no_wr;
  assign no_wr = !cfg_we && !cmp_lo_we && !cmp_hi_we;

  p_fire_after_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(cnt_tick));

  p_fire_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(cfg_rd[0] && glb_en));

  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd[0] && no_wr) |=> ($stable(cmp_rd) && $stable(period_rd)));

  p_mode32_hi_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd[2] |-> (cmp_rd[CNT_W-1:HALF] == '0 && period_rd[CNT_W-1:HALF] == '0));

  p_period_top_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !period_rd[CNT_W-1]);

  p_zero_period_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_rd == '0 && no_wr) |=> $stable(cmp_rd));

endmodule

bind etc_channel etc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_tick  (cnt_tick),
  .glb_en    (glb_en),
  .cfg_we    (cfg_we),
  .cmp_lo_we (cmp_lo_we),
  .cmp_hi_we (cmp_hi_we),
  .cfg_rd    (cfg_rd),
  .cmp_rd    (cmp_rd),
  .period_rd (period_rd),
  .fire      (fire)
);

// File: tb/tb_etc_channel.sv
module tb_etc_channel;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cnt_val = '0;
  logic              cnt_tick = 1'b0;
  logic              glb_en = 1'b0;
  logic              cfg_we = 1'b0;
  logic [3:0]        cfg_wdata = '0;
  logic              cmp_lo_we = 1'b0;
  logic              cmp_hi_we = 1'b0;
  logic [31:0]       cmp_wdata = '0;
  logic [5:0]        cfg_rd;
  logic [CNT_W-1:0]  cmp_rd;
  logic [CNT_W-1:0]  period_rd;
  logic              fire;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  etc_channel #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .glb_en(glb_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmp_lo_we(cmp_lo_we), .cmp_hi_we(cmp_hi_we), .cmp_wdata(cmp_wdata),
    .cfg_rd(cfg_rd), .cmp_rd(cmp_rd), .period_rd(period_rd), .fire(fire)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; glb_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_lo(input logic [31:0] v);
    cmp_lo_we = 1'b1; cmp_wdata = v;
    @(posedge clk); @(negedge clk);
    cmp_lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [31:0] v);
    cmp_hi_we = 1'b1; cmp_wdata = v;
    @(posedge clk); @(negedge clk);
    cmp_hi_we = 1'b0;
  endtask

  // applies one tick and leaves the fire value of the following cycle in f
  task automatic tick(input logic [63:0] c, output logic f);
    cnt_val = c; cnt_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    cnt_tick = 1'b0;
    f = fire;
  endtask

  // periodic load of comparator and period using set-value on each half
  task automatic load_periodic(input logic [3:0] base, input logic [63:0] v);
    wr_cfg(base | 4'b1000); wr_hi(v[63:32]);
    wr_cfg(base | 4'b1000); wr_lo(v[31:0]);
  endtask

  task automatic t_reset();
    do_reset();
    check(cfg_rd == 6'h30, "R1 cfg", {58'd0, cfg_rd}, 64'h30);
    check(cmp_rd == '1, "R1 cmp", cmp_rd, '1);
    check(period_rd == '0, "R1 period", period_rd, 0);
    check(fire == 1'b0, "R1 fire", {63'd0, fire}, 0);
  endtask

  task automatic t_oneshot64();
    logic f;
    do_reset();
    glb_en = 1'b1;
    wr_lo(32'd100); wr_hi(32'd1);
    wr_cfg(4'b0001);
    tick(64'd99, f);  check(!f, "R2 no fire before match", {63'd0, f}, 0);
    tick(64'd100, f); check(!f, "R3 upper half differs", {63'd0, f}, 0);
    tick({32'd1, 32'd100}, f); check(f, "R2 fire on match", {63'd0, f}, 1);
    @(negedge clk);
    check(!fire, "R2 fire one cycle", {63'd0, fire}, 0);
    check(cmp_rd == {32'd1, 32'd100}, "R3 one-shot cmp kept", cmp_rd, {32'd1, 32'd100});
    tick({32'd1, 32'd0}, f); check(!f, "R5 no wrap event in 64-bit", {63'd0, f}, 0);
  endtask

  task automatic t_mode32();
    logic f;
    do_reset();
    glb_en = 1'b1;
    wr_lo(32'd5); wr_hi(32'd1);
    wr_cfg(4'b0101);
    check(cmp_rd == 64'd5, "R4 truncation", cmp_rd, 64'd5);
    wr_hi(32'd9);
    check(cmp_rd == 64'd5, "R4 high write ignored", cmp_rd, 64'd5);
    tick({32'd7, 32'd5}, f); check(f, "R4 low-half compare", {63'd0, f}, 1);
    wr_lo(32'd50);
    tick({32'd0, 32'hFFFF_FFFF}, f); check(!f, "R5 before wrap", {63'd0, f}, 0);
    tick({32'd1, 32'd0}, f); check(f, "R5 wrap event", {63'd0, f}, 1);
    check(cmp_rd == 64'd50, "R5 cmp kept", cmp_rd, 64'd50);
  endtask

  task automatic t_periodic();
    logic f;
    do_reset();
    glb_en = 1'b1;
    load_periodic(4'b0011, 64'd1000);
    check(cfg_rd[3] == 1'b0, "R6 setval cleared", {63'd0, cfg_rd[3]}, 0);
    check(cmp_rd == 64'd1000, "R6 cmp via setval", cmp_rd, 64'd1000);
    check(period_rd == 64'd1000, "R6 period", period_rd, 64'd1000);
    tick(64'd1000, f); check(f, "R7 periodic fire", {63'd0, f}, 1);
    check(cmp_rd == 64'd2000, "R7 reload", cmp_rd, 64'd2000);
    tick(64'd2000, f); check(cmp_rd == 64'd3000, "R7 second reload", cmp_rd, 64'd3000);
    wr_lo(32'd500);
    check(cmp_rd == 64'd3000, "R6 cmp kept without setval", cmp_rd, 64'd3000);
    check(period_rd == 64'd500, "R6 period updated", period_rd, 64'd500);
    tick(64'd3000, f); check(cmp_rd == 64'd3500, "R7 new period", cmp_rd, 64'd3500);
    tick(64'd3000, f); check(!f, "R2 stale value", {63'd0, f}, 0);
  endtask

  task automatic t_periodic32();
    logic f;
    do_reset();
    glb_en = 1'b1;
    wr_cfg(4'b1111); wr_lo(32'hFFFF_FFF0);
    check(period_rd == 64'h7FFF_FFF0, "R8 bit31 masked", period_rd, 64'h7FFF_FFF0);
    wr_lo(32'h20);
    check(cmp_rd == 64'hFFFF_FFF0, "R6 cmp kept", cmp_rd, 64'hFFFF_FFF0);
    tick({32'd5, 32'hFFFF_FFF0}, f); check(f, "R7 fire 32", {63'd0, f}, 1);
    check(cmp_rd == 64'h10, "R7 truncated reload", cmp_rd, 64'h10);
    tick({32'd6, 32'd0}, f); check(!f, "R5 no wrap in periodic", {63'd0, f}, 0);
  endtask

  task automatic t_mask64();
    do_reset();
    wr_cfg(4'b0010); wr_hi(32'hFFFF_FFFF);
    check(period_rd == 64'h7FFF_FFFF_0000_0000, "R8 bit63 masked",
          period_rd, 64'h7FFF_FFFF_0000_0000);
  endtask

  task automatic t_zero_period();
    logic f;
    do_reset();
    glb_en = 1'b1;
    load_periodic(4'b0011, 64'd0);
    tick(64'd0, f); check(f, "R9 fires", {63'd0, f}, 1);
    check(cmp_rd == 64'd0, "R9 no reload", cmp_rd, 0);
  endtask

  task automatic t_disabled();
    logic f;
    do_reset();
    glb_en = 1'b1;
    load_periodic(4'b0010, 64'd100);
    tick(64'd100, f); check(!f, "R10 channel off", {63'd0, f}, 0);
    check(cmp_rd == 64'd100, "R10 cmp held", cmp_rd, 64'd100);
    check(period_rd == 64'd100, "R10 period held", period_rd, 64'd100);
    wr_cfg(4'b0011);
    glb_en = 1'b0;
    tick(64'd100, f); check(!f, "R10 global off", {63'd0, f}, 0);
    check(cmp_rd == 64'd100, "R10 cmp held global", cmp_rd, 64'd100);
    glb_en = 1'b1;
    tick(64'd100, f); check(f, "R10 re-enabled", {63'd0, f}, 1);
    check(cmp_rd == 64'd200, "R7 reload after enable", cmp_rd, 64'd200);
  endtask

  initial begin
    t_reset();
    t_oneshot64();
    t_mode32();
    t_periodic();
    t_periodic32();
    t_mask64();
    t_zero_period();
    t_disabled();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule